// File: doc/BRIEF.md
# YCbCr Output Formatter with Color Killer

This block takes decoded luma and chroma samples, one pixel per clock while a line-valid strobe is high, and puts them on two 8-bit output buses. It has three output arrangements: a dual-bus 4:2:2 mode (luma on one bus, the two colour-difference components taking turns on the other), a 4:1:1 mode that packs each four-pixel group's chroma into 2-bit pieces, and a single-bus mode that interleaves chroma and luma bytes at twice the pixel rate with no timing-reference codes.

Before formatting, the chroma path passes through a color killer. It blanks chroma when the measured burst amplitude is below a selectable fraction of a reference, or at all times when a force bit is set. When automatic blue screen is enabled and the upstream sync detector reports no lock, a fixed blue picture replaces the decoded samples. Each output bus can then be delayed by 0 to 3 clocks on its own, so that downstream capture logic can line the buses up.

Top module: `ycc_out_fmt`

## Requirements
- R1: During and directly after reset, `y_out` is 16 and `c_out` is 128.
- R2: A clock in which `hvalid` is low produces `y_out`=16 and `c_out`=128 two clocks later (phase 0).
- R3: With `mux_en`=0 and `fmt_411`=0, `y_out` carries each pixel's luma. `c_out` carries the Cb of pixels at even positions and the Cr of pixels at odd positions, where position 0 is the first pixel after `hvalid` rises.
- R4: With `fmt_411`=1 and `mux_en`=0, chroma is taken from the first pixel of each four-pixel group. At group position j (0..3), `c_out` is {Cb[7-2j:6-2j], Cr[7-2j:6-2j], 4'b0000}.
- R5: With `mux_en`=1 the pixel rate is half the clock and each pixel is held for two clocks. `y_out` repeats Cb0, Y0, Cr0, Y1 per pixel pair, with Cr0 taken from the first pixel, and `c_out` stays at 128.
- R6: The automatic killer forces Cb and Cr to 128 when `burst_lvl` × F < `burst_ref`. `kill_sel` selects F: 00 gives 2 (half), 01 gives 4 (quarter), 10 gives 8 (eighth). Equality does not kill.
- R7: With `kill_sel`=11 the automatic killer is off whatever the burst level.
- R8: With `kill_force`=1, Cb and Cr are 128 regardless of the burst level.
- R9: With `blue_auto`=1 and `sync_ok`=0, every active pixel becomes Y=41, Cb=240, Cr=110.
- R10: With `blue_auto`=0, `sync_ok` has no effect and decoded data passes through.
- R11: `y_phase` and `c_phase` each add that many clocks (0 to 3) of delay to their own bus, independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hvalid | input | 1 | Active-pixel strobe |
| y_in | input | 8 | Decoded luma |
| cb_in | input | 8 | Decoded Cb (offset binary) |
| cr_in | input | 8 | Decoded Cr (offset binary) |
| burst_lvl | input | 8 | Measured burst amplitude |
| burst_ref | input | 8 | Burst reference amplitude |
| sync_ok | input | 1 | Sync lock from upstream detector |
| kill_sel | input | 2 | Killer threshold select |
| kill_force | input | 1 | Force chroma to zero |
| blue_auto | input | 1 | Enable blue screen when unlocked |
| fmt_411 | input | 1 | Select 4:1:1 packing |
| mux_en | input | 1 | Select single-bus interleaved output |
| y_phase | input | 2 | Extra delay of the Y bus in clocks |
| c_phase | input | 2 | Extra delay of the C bus in clocks |
| y_out | output | 8 | Y bus (or interleaved bus) |
| c_out | output | 8 | C bus |

## Verification
A sample presented before rising edge k reaches the output registers at edge k+2. It then appears after 2 + `y_phase` or 2 + `c_phase` edges on its bus. The bench drives inputs on falling edges and compares each bus on the falling edge that follows that many rising edges, keeping a separate offset for each bus. Single-pixel table vectors use a one-clock `hvalid` pulse, so their chroma is always at position 0 and is checked two falling edges after the drive.

// File: rtl/ycc_out_fmt.sv
module ycc_out_fmt #(
  parameter int DW     = 8,
  parameter int PH_MAX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hvalid,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] cb_in,
  input  logic [DW-1:0] cr_in,
  input  logic [DW-1:0] burst_lvl,
  input  logic [DW-1:0] burst_ref,
  input  logic          sync_ok,
  input  logic [1:0]    kill_sel,
  input  logic          kill_force,
  input  logic          blue_auto,
  input  logic          fmt_411,
  input  logic          mux_en,
  input  logic [1:0]    y_phase,
  input  logic [1:0]    c_phase,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] c_out
);
  localparam int CW = DW + 3;
  localparam logic [DW-1:0] Y_BLK  = DW'(16);
  localparam logic [DW-1:0] C_MID  = DW'(128);
  localparam logic [DW-1:0] Y_BLUE = DW'(41);
  localparam logic [DW-1:0] B_BLUE = DW'(240);
  localparam logic [DW-1:0] R_BLUE = DW'(110);

  // killer threshold compare
  logic [CW-1:0] lvl_sc;
  always_comb begin
    case (kill_sel)
      2'b00:   lvl_sc = {3'b000, burst_lvl} << 1;
      2'b01:   lvl_sc = {3'b000, burst_lvl} << 2;
      default: lvl_sc = {3'b000, burst_lvl} << 3;
    endcase
  end

  wire kill_auto = (kill_sel != 2'b11) && (lvl_sc < {3'b000, burst_ref});
  wire kill      = kill_force | kill_auto;
  wire blue      = blue_auto & ~sync_ok;

  // stage A: substitution
  logic          hv_a;
  logic [1:0]    cnt_a;
  logic [DW-1:0] y_a, cb_a, cr_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv_a  <= 1'b0;
      cnt_a <= 2'd0;
      y_a   <= Y_BLK;
      cb_a  <= C_MID;
      cr_a  <= C_MID;
    end else begin
      hv_a  <= hvalid;
      cnt_a <= (hvalid && !hv_a) ? 2'd0 : cnt_a + 2'd1;
      if (!hvalid) begin
        y_a  <= Y_BLK;
        cb_a <= C_MID;
        cr_a <= C_MID;
      end else if (blue) begin
        y_a  <= Y_BLUE;
        cb_a <= B_BLUE;
        cr_a <= R_BLUE;
      end else begin
        y_a  <= y_in;
        cb_a <= kill ? C_MID : cb_in;
        cr_a <= kill ? C_MID : cr_in;
      end
    end
  end

  // stage B: formatting
  logic [DW-1:0] y_b, c_b, grp_cb, grp_cr;
  logic [DW-1:0] y_nx, c_nx, src_cb, src_cr;
  logic [1:0]    pc_cb, pc_cr;

  assign src_cb = (cnt_a == 2'd0) ? cb_a : grp_cb;
  assign src_cr = (cnt_a == 2'd0) ? cr_a : grp_cr;

  always_comb begin
    case (cnt_a)
      2'd0:    begin pc_cb = src_cb[7:6]; pc_cr = src_cr[7:6]; end
      2'd1:    begin pc_cb = src_cb[5:4]; pc_cr = src_cr[5:4]; end
      2'd2:    begin pc_cb = src_cb[3:2]; pc_cr = src_cr[3:2]; end
      default: begin pc_cb = src_cb[1:0]; pc_cr = src_cr[1:0]; end
    endcase
  end

  always_comb begin
    y_nx = Y_BLK;
    c_nx = C_MID;
    if (hv_a) begin
      if (mux_en) begin
        case (cnt_a)
          2'd0:    y_nx = cb_a;
          2'd2:    y_nx = grp_cr;
          default: y_nx = y_a;
        endcase
      end else begin
        y_nx = y_a;
        if (fmt_411) c_nx = {pc_cb, pc_cr, {(DW-4){1'b0}}};
        else         c_nx = cnt_a[0] ? cr_a : cb_a;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_b    <= Y_BLK;
      c_b    <= C_MID;
      grp_cb <= C_MID;
      grp_cr <= C_MID;
    end else begin
      y_b <= y_nx;
      c_b <= c_nx;
      if (cnt_a == 2'd0) begin
        grp_cb <= cb_a;
        grp_cr <= cr_a;
      end
    end
  end

  // phase delay lines
  logic [DW-1:0] y_d [PH_MAX];
  logic [DW-1:0] c_d [PH_MAX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PH_MAX; i++) begin
        y_d[i] <= Y_BLK;
        c_d[i] <= C_MID;
      end
    end else begin
      y_d[0] <= y_b;
      c_d[0] <= c_b;
      for (int i = 1; i < PH_MAX; i++) begin
        y_d[i] <= y_d[i-1];
        c_d[i] <= c_d[i-1];
      end
    end
  end

  assign y_out = (y_phase == 2'd0) ? y_b : y_d[y_phase - 2'd1];
  assign c_out = (c_phase == 2'd0) ? c_b : c_d[c_phase - 2'd1];

  AST_RESET_BLANK: assert property (@(posedge clk) !rst_n |=> (y_b == Y_BLK && c_b == C_MID)); // R1
  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n) !hvalid |=> (y_a == Y_BLK && cb_a == C_MID && cr_a == C_MID)); // R2
  AST_FIRST_CB: assert property (@(posedge clk) disable iff (!rst_n) (hv_a && !mux_en && !fmt_411 && cnt_a == 2'd0) |=> c_b == $past(cb_a)); // R3
  AST_MUX_CMID: assert property (@(posedge clk) disable iff (!rst_n) (hv_a && mux_en) |=> c_b == C_MID); // R5
  AST_FORCE_KILL: assert property (@(posedge clk) disable iff (!rst_n) (hvalid && kill_force && sync_ok) |=> (cb_a == C_MID && cr_a == C_MID)); // R8
  AST_BLUE_SUB: assert property (@(posedge clk) disable iff (!rst_n) (hvalid && blue_auto && !sync_ok) |=> (y_a == Y_BLUE && cb_a == B_BLUE && cr_a == R_BLUE)); // R9
  AST_Y_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (y_phase == 2'd1) |-> y_out == $past(y_b)); // R11
endmodule

// File: tb/sim_ycc_out_fmt.sv
module sim_ycc_out_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hvalid = 1'b0;
  logic [7:0] y_in = 8'd0, cb_in = 8'd0, cr_in = 8'd0;
  logic [7:0] burst_lvl = 8'd0, burst_ref = 8'd0;
  logic sync_ok = 1'b1, kill_force = 1'b0, blue_auto = 1'b0;
  logic fmt_411 = 1'b0, mux_en = 1'b0;
  logic [1:0] kill_sel = 2'b11, y_phase = 2'd0, c_phase = 2'd0;
  logic [7:0] y_out, c_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ycc_out_fmt u0 (
    .clk(clk), .rst_n(rst_n), .hvalid(hvalid),
    .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
    .burst_lvl(burst_lvl), .burst_ref(burst_ref), .sync_ok(sync_ok),
    .kill_sel(kill_sel), .kill_force(kill_force), .blue_auto(blue_auto),
    .fmt_411(fmt_411), .mux_en(mux_en), .y_phase(y_phase), .c_phase(c_phase),
    .y_out(y_out), .c_out(c_out)
  );

  // {ctl, lvl, ref, y, cb, cr, exp_y, exp_c}; ctl = {kill_sel, force, blue_auto, sync_ok, 3'b0}
  localparam logic [63:0] VEC [NVEC] = '{
    {8'h48, 8'd40,  8'd100, 8'd80, 8'd90,  8'd48, 8'd80, 8'd90},   // R6 quarter, no kill
    {8'h48, 8'd20,  8'd100, 8'd81, 8'd91,  8'd49, 8'd81, 8'd128},  // R6 quarter, kill
    {8'h08, 8'd60,  8'd100, 8'd82, 8'd200, 8'd50, 8'd82, 8'd200},  // R6 half, no kill
    {8'h08, 8'd49,  8'd100, 8'd83, 8'd201, 8'd51, 8'd83, 8'd128},  // R6 half, kill
    {8'h88, 8'd12,  8'd100, 8'd84, 8'd202, 8'd52, 8'd84, 8'd128},  // R6 eighth, kill
    {8'h88, 8'd13,  8'd100, 8'd85, 8'd203, 8'd53, 8'd85, 8'd203},  // R6 eighth, no kill
    {8'hC8, 8'd0,   8'd255, 8'd86, 8'd204, 8'd54, 8'd86, 8'd204},  // R7 killer off
    {8'hE8, 8'd200, 8'd100, 8'd87, 8'd205, 8'd55, 8'd87, 8'd128},  // R8 forced
    {8'hD0, 8'd200, 8'd100, 8'd88, 8'd206, 8'd56, 8'd41, 8'd240},  // R9 blue
    {8'hC0, 8'd200, 8'd100, 8'd89, 8'd207, 8'd57, 8'd89, 8'd207},  // R10 no lock, blue off
    {8'hD8, 8'd200, 8'd100, 8'd90, 8'd208, 8'd58, 8'd90, 8'd208},  // R9 locked, pass
    {8'h48, 8'd25,  8'd100, 8'd91, 8'd209, 8'd59, 8'd91, 8'd209}   // R6 equality, no kill
  };

  logic [7:0] sy [16], scb [16], scr [16], ey [16], ec [16];

  task automatic check(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic apply_ctl(input logic [7:0] ctl);
    kill_sel   = ctl[7:6];
    kill_force = ctl[5];
    blue_auto  = ctl[4];
    sync_ok    = ctl[3];
  endtask

  task automatic run_stream(input int n, input int yp, input int cp, input string rq);
    for (int i = 0; i < n + 8; i++) begin
      @(negedge clk);
      if (i - 2 - yp >= 0 && i - 2 - yp < n) check(rq, "y stream", y_out, ey[i-2-yp]);
      if (i - 2 - cp >= 0 && i - 2 - cp < n) check(rq, "c stream", c_out, ec[i-2-cp]);
      if (i < n) begin
        hvalid = 1'b1;
        y_in = sy[i]; cb_in = scb[i]; cr_in = scr[i];
      end else begin
        hvalid = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    y_in = 8'd77; cb_in = 8'd99; cr_in = 8'd33;
    repeat (3) @(negedge clk);
    check("R1", "y reset", y_out, 8'd16);
    check("R1", "c reset", c_out, 8'd128);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", "y idle", y_out, 8'd16);
    check("R2", "c idle", c_out, 8'd128);

    // vector table: single pixel pulses at position 0
    for (int v = 0; v < NVEC; v++) begin
      apply_ctl(VEC[v][63:56]);
      burst_lvl = VEC[v][55:48];
      burst_ref = VEC[v][47:40];
      y_in  = VEC[v][39:32];
      cb_in = VEC[v][31:24];
      cr_in = VEC[v][23:16];
      hvalid = 1'b1;
      @(negedge clk);
      hvalid = 1'b0;
      @(negedge clk);
      check("R6-R10 table", "y", y_out, VEC[v][15:8]);
      check("R6-R10 table", "c", c_out, VEC[v][7:0]);
      @(negedge clk);
    end
    apply_ctl(8'hC8);

    // R2: after a pixel the idle value returns
    check("R2", "y after pulse", y_out, 8'd16);

    // R3: 4:2:2 alternation
    for (int i = 0; i < 4; i++) begin
      sy[i] = 8'(10 + 10*i); scb[i] = 8'(50 + 10*i); scr[i] = 8'(90 + 10*i);
      ey[i] = sy[i];
      ec[i] = (i % 2 == 0) ? scb[i] : scr[i];
    end
    run_stream(4, 0, 0, "R3");

    // R11: independent phases, same stream
    @(negedge clk); y_phase = 2'd2; c_phase = 2'd1;
    run_stream(4, 2, 1, "R11");
    @(negedge clk); y_phase = 2'd3; c_phase = 2'd0;
    run_stream(4, 3, 0, "R11");
    @(negedge clk); y_phase = 2'd0;

    // R4: 4:1:1 packing, Cb0=0xB4 Cr0=0x1E
    fmt_411 = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sy[i] = 8'(100 + i); scb[i] = 8'h11; scr[i] = 8'h22; ey[i] = sy[i];
    end
    scb[0] = 8'hB4; scr[0] = 8'h1E;
    ec[0] = 8'h80; ec[1] = 8'hD0; ec[2] = 8'h70; ec[3] = 8'h20;
    run_stream(4, 0, 0, "R4");
    fmt_411 = 1'b0;

    // R5: single bus interleave, pixels held for two clocks
    mux_en = 1'b1;
    sy[0] = 8'd10; scb[0] = 8'd50; scr[0] = 8'd90;
    sy[1] = 8'd10; scb[1] = 8'd50; scr[1] = 8'd90;
    sy[2] = 8'd20; scb[2] = 8'd60; scr[2] = 8'd100;
    sy[3] = 8'd20; scb[3] = 8'd60; scr[3] = 8'd100;
    ey[0] = 8'd50; ey[1] = 8'd10; ey[2] = 8'd90; ey[3] = 8'd20;
    for (int i = 0; i < 4; i++) ec[i] = 8'd128;
    run_stream(4, 0, 0, "R5");
    mux_en = 1'b0;

    // R9: blue screen over a two-pixel stream shows Cb then Cr
    apply_ctl(8'hD0);
    for (int i = 0; i < 2; i++) begin
      sy[i] = 8'd200; scb[i] = 8'd20; scr[i] = 8'd30; ey[i] = 8'd41;
    end
    ec[0] = 8'd240; ec[1] = 8'd110;
    run_stream(2, 0, 0, "R9");

    // R8: forced kill also clears Cr at odd positions
    apply_ctl(8'hE8);
    for (int i = 0; i < 2; i++) begin
      sy[i] = 8'(60 + i); scb[i] = 8'd20; scr[i] = 8'd30; ey[i] = sy[i]; ec[i] = 8'd128;
    end
    run_stream(2, 0, 0, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule